// File: doc/BRIEF.md
# Multichannel ADC Sample Sequencer

This block sequences an external successive-approximation converter. Software loads a list of up to eight slots. Each slot names one of eight analog inputs. The block then starts one conversion per slot through a request/acknowledge port, with a programmable gap between consecutive conversions. Every result is tagged with the input it came from and stored in a 32-entry result queue. Software reads the queue and the engine status through a small word-wide register port. An interrupt line signals when the queue holds enough results.

A run is either single-shot, walking slots 0 up to the last programmed index once, or continuous, wrapping back to slot 0 until software asks it to stop. A stop request never cuts a conversion short. The conversion in flight completes and its result is stored in the same clock edge at which the busy flags drop.

Top module: `sar_sequencer`

## Requirements
- R1: After reset the control/status word (address 0) reads 0x0400_0000, meaning only the empty flag (bit 26) is set. `convReq` and `irq` are low, and the slot-list word (address 1) reads 0.
- R2: A write to address 0 with the enable bit (bit 0) and the start bit (bit 2) both set, made while idle, raises busy bit 28 on the next clock. In that same cycle it raises `convReq` with `convChan` equal to the slot-0 channel.
- R3: Slots run in order from slot 0 up to the last index held in bits 26:24 of the slot-list word. Slot k takes its channel from bits 3k+2:3k. In single-shot mode (bit 1 clear) the engine goes idle after the last slot, so a last index of 0 gives exactly one conversion.
- R4: With continuous mode (bit 1) set, the slot after the last one is slot 0 again, and the sequence repeats until a stop request.
- R5: A read of address 3 pops the oldest result. The word carries the channel tag in bits 14:12 and the 12-bit code in bits 11:0, and results come out in conversion order.
- R6: Status fields in address 0: bit 28 is set while a run is active, bit 29 while a conversion request is outstanding, bit 30 while the inter-sample gap runs, bit 27 when the queue is full, bit 26 when it is empty, and bits 25:21 hold the occupancy modulo 32.
- R7: Between an acknowledge and the next request, `convReq` stays low for exactly (N+1)·4^S cycles. N is bits 7:0 and S is bits 9:8 of the gap word (address 2).
- R8: A stop request (address 0 write with bit 14 set) lets the conversion in flight finish. Its result is stored, and the busy flags clear at that same edge. A stop made during a gap ends the run on the next clock. No request follows a stop.
- R9: A start written while the engine is busy has no effect on the slot order or on the number of results. A start written without the enable bit also has no effect.
- R10: A read of address 3 while the queue is empty returns 0 and leaves the occupancy at 0.
- R11: A result arriving while the queue holds 32 entries is discarded. The occupancy stays 32 and the 32 oldest results are kept.
- R12: `irq` is high while the interrupt enable (bit 3) is set and the occupancy is at least the threshold in bits 8:4, where a threshold of 0 counts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops the queue at address 3) |
| regAddr | input | 2 | Word address: 0 control/status, 1 slot list, 2 gap, 3 result queue |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational from the current address |
| convReq | output | 1 | Conversion request, held until acknowledged |
| convChan | output | 3 | Input to convert for the current slot |
| convAck | input | 1 | One-cycle acknowledge carrying the result |
| convData | input | 12 | Conversion code, valid with `convAck` |
| irq | output | 1 | Queue-threshold interrupt (level) |

## Verification
A wrong slot index in the engine shows on `convChan` at the very next request. The converter model compares it against the programmed order, so it is caught within one conversion. A lost or duplicated queue write shows when the bench drains the queue and compares each tag and code against the scoreboard. It also shows in the status occupancy read when the run goes idle. A wrong gap count shows as a wrong number of low cycles on `convReq` before the next request. A stop that is handled too early or too late shows as a mismatch between the acknowledges issued and the occupancy reported once busy clears.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;
  localparam int TAG_W    = 3;
  localparam int SAMPLE_W = 12;
  localparam int SLOT_W   = 3;
  localparam int SLOTS    = 1 << SLOT_W;
  localparam int WORD_W   = TAG_W + SAMPLE_W;
  localparam int THR_W    = 5;
  localparam int CNTF_W   = 5;
  localparam int DATA_W   = 32;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_LIST = 2'd1;
  localparam logic [1:0] ADDR_GAP  = 2'd2;
  localparam logic [1:0] ADDR_FIFO = 2'd3;

  localparam int B_EN        = 0;
  localparam int B_CONT      = 1;
  localparam int B_START     = 2;
  localparam int B_IRQEN     = 3;
  localparam int B_THR_LO    = 4;
  localparam int B_STOP      = 14;
  localparam int B_CNT_LO    = 21;
  localparam int B_EMPTY     = 26;
  localparam int B_FULL      = 27;
  localparam int B_BUSY_LO   = 28;
  localparam int B_MAXIDX_LO = 24;

  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_GAP} seqState_t;

  // control -> datapath
  typedef struct packed {
    logic              push;
    logic              gapLoad;
    logic              gapRun;
    logic [SLOT_W-1:0] slot;
    logic [2:0]        busy;   // {gap, conversion, run}
  } seqStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic              startHit;
    logic              stopHit;
    logic              contMode;
    logic [SLOT_W-1:0] lastSlot;
    logic              gapDone;
  } seqView_t;
endpackage

// File: rtl/sarseq_datapath.sv
module sarseq_datapath
  import sarseq_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int TICK_SHIFT = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [1:0]          regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  input  seqStrobe_t          strb,
  output seqView_t            view,
  input  logic [SAMPLE_W-1:0] convData,
  output logic [TAG_W-1:0]    convChan,
  output logic                irq
);
  localparam int PTR_W   = $clog2(FIFO_DEPTH);
  localparam int CNT_W   = PTR_W + 1;
  localparam int PRE_W   = TICK_SHIFT * 3;
  localparam int LIST_W  = SLOTS * TAG_W;

  // configuration registers
  logic              enReg, contReg, irqEnReg;
  logic [THR_W-1:0]  thrReg;
  logic [LIST_W-1:0] listReg;
  logic [SLOT_W-1:0] lastSlotReg;
  logic [7:0]        gapCntReg;
  logic [1:0]        gapSelReg;

  wire unusedWdata = ^regWdata[DATA_W-1:B_MAXIDX_LO+SLOT_W];

  logic ctrlWr;
  assign ctrlWr = regWrEn && regAddr == ADDR_CTRL;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg       <= 1'b0;
      contReg     <= 1'b0;
      irqEnReg    <= 1'b0;
      thrReg      <= '0;
      listReg     <= '0;
      lastSlotReg <= '0;
      gapCntReg   <= '0;
      gapSelReg   <= '0;
    end else if (regWrEn) begin
      unique case (regAddr)
        ADDR_CTRL: begin
          enReg    <= regWdata[B_EN];
          contReg  <= regWdata[B_CONT];
          irqEnReg <= regWdata[B_IRQEN];
          thrReg   <= regWdata[B_THR_LO +: THR_W];
        end
        ADDR_LIST: begin
          listReg     <= regWdata[LIST_W-1:0];
          lastSlotReg <= regWdata[B_MAXIDX_LO +: SLOT_W];
        end
        ADDR_GAP: begin
          gapCntReg <= regWdata[7:0];
          gapSelReg <= regWdata[9:8];
        end
        default: ;
      endcase
    end
  end

  // slot -> channel lookup
  logic [TAG_W-1:0] slotChan [SLOTS];
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign slotChan[k] = listReg[k*TAG_W +: TAG_W];
  end
  assign convChan = slotChan[strb.slot];

  // result queue
  logic [WORD_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              full, empty, popReq, doPush, doPop;

  assign full   = count == CNT_W'(FIFO_DEPTH);
  assign empty  = count == '0;
  assign popReq = regRdEn && regAddr == ADDR_FIFO;
  assign doPush = strb.push && !full;
  assign doPop  = popReq && !empty;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= {convChan, convData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(FIFO_DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(FIFO_DEPTH-1)) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  // inter-sample gap: prescaler of 4^sel cycles, (cnt+1) ticks
  logic [PRE_W-1:0] preLoad, preLeft;
  logic [7:0]       gapLeft;
  assign preLoad = PRE_W'((32'd1 << (TICK_SHIFT * int'(gapSelReg))) - 32'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preLeft <= '0;
      gapLeft <= '0;
    end else if (strb.gapLoad) begin
      preLeft <= preLoad;
      gapLeft <= gapCntReg;
    end else if (strb.gapRun) begin
      if (preLeft == '0) begin
        preLeft <= preLoad;
        if (gapLeft != '0) gapLeft <= gapLeft - 1'b1;
      end else begin
        preLeft <= preLeft - 1'b1;
      end
    end
  end

  always_comb begin
    view          = '0;
    view.startHit = ctrlWr && regWdata[B_START] && regWdata[B_EN];
    view.stopHit  = ctrlWr && regWdata[B_STOP];
    view.contMode = contReg;
    view.lastSlot = lastSlotReg;
    view.gapDone  = strb.gapRun && preLeft == '0 && gapLeft == '0;
  end

  // interrupt
  logic [THR_W-1:0] thrEff;
  assign thrEff = (thrReg == '0) ? THR_W'(1) : thrReg;
  assign irq    = irqEnReg && (count >= CNT_W'(thrEff));

  // register read
  logic [DATA_W-1:0] ctrlWord;
  always_comb begin
    ctrlWord                         = '0;
    ctrlWord[B_EN]                   = enReg;
    ctrlWord[B_CONT]                 = contReg;
    ctrlWord[B_IRQEN]                = irqEnReg;
    ctrlWord[B_THR_LO +: THR_W]      = thrReg;
    ctrlWord[B_CNT_LO +: CNTF_W]     = CNTF_W'(count);
    ctrlWord[B_EMPTY]                = empty;
    ctrlWord[B_FULL]                 = full;
    ctrlWord[B_BUSY_LO +: 3]         = strb.busy;
    unique case (regAddr)
      ADDR_CTRL: regRdata = ctrlWord;
      ADDR_LIST: regRdata = {5'b0, lastSlotReg, listReg};
      ADDR_GAP:  regRdata = {22'b0, gapSelReg, gapCntReg};
      default:   regRdata = empty ? '0 : {{(DATA_W-WORD_W){1'b0}}, mem[rdPtr]};
    endcase
  end

  // checks
  a_r11_bounded: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(FIFO_DEPTH));
  a_r11_full_drop: assert property (@(posedge clk) disable iff (!rstN)
    (full && strb.push && !popReq) |=> (full && $stable(wrPtr)));
  a_r10_empty_read: assert property (@(posedge clk) disable iff (!rstN)
    (empty && popReq && !strb.push) |=> (empty && $stable(rdPtr)));
  a_r12_irq_has_data: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !empty);
endmodule

// File: rtl/sarseq_ctrl.sv
module sarseq_ctrl
  import sarseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  seqView_t   view,
  input  logic       convAck,
  output logic       convReq,
  output seqStrobe_t strb
);
  seqState_t         state, stateNext;
  logic [SLOT_W-1:0] slot, slotNext;
  logic              stopPend, stopPendNext, atLast;

  assign atLast  = slot >= view.lastSlot;
  assign convReq = state == ST_CONV;

  always_comb begin
    stateNext    = state;
    slotNext     = slot;
    stopPendNext = stopPend;
    strb         = '0;
    strb.slot    = slot;
    strb.busy    = {state == ST_GAP, state == ST_CONV, state != ST_IDLE};
    unique case (state)
      ST_IDLE: begin
        if (view.startHit) begin
          stateNext    = ST_CONV;
          slotNext     = '0;
          stopPendNext = 1'b0;
        end
      end
      ST_CONV: begin
        if (view.stopHit) stopPendNext = 1'b1;
        if (convAck) begin
          strb.push = 1'b1;
          if (stopPend || view.stopHit || (atLast && !view.contMode)) begin
            stateNext    = ST_IDLE;
            stopPendNext = 1'b0;
          end else begin
            stateNext    = ST_GAP;
            strb.gapLoad = 1'b1;
            slotNext     = atLast ? '0 : slot + 1'b1;
          end
        end
      end
      ST_GAP: begin
        strb.gapRun = 1'b1;
        if (view.stopHit)      stateNext = ST_IDLE;
        else if (view.gapDone) stateNext = ST_CONV;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      slot     <= '0;
      stopPend <= 1'b0;
    end else begin
      state    <= stateNext;
      slot     <= slotNext;
      stopPend <= stopPendNext;
    end
  end

  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && view.startHit) |=> (strb.busy[0] && convReq));
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (convReq && !convAck) |=> (convReq && $stable(slot)));
  a_r8_drain_stop: assert property (@(posedge clk) disable iff (!rstN)
    (convReq && convAck && stopPend) |=> (!convReq && !strb.busy[0]));
  a_r9_busy_start_kept_slot: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV && view.startHit && !convAck) |=> $stable(slot));
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sarseq_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int TICK_SHIFT = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        convReq,
  output logic [2:0]  convChan,
  input  logic        convAck,
  input  logic [11:0] convData,
  output logic        irq
);
  seqStrobe_t strb;
  seqView_t   view;

  sarseq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .view    (view),
    .convAck (convAck),
    .convReq (convReq),
    .strb    (strb)
  );

  sarseq_datapath #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .TICK_SHIFT (TICK_SHIFT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .strb     (strb),
    .view     (view),
    .convData (convData),
    .convChan (convChan),
    .irq      (irq)
  );
endmodule

// File: tb/sar_sequencer_tb.sv
module sar_sequencer_tb;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        convReq, irq;
  logic [2:0]  convChan;
  logic        convAck = 1'b0;
  logic [11:0] convData = '0;

  always #5 clk = ~clk;

  sar_sequencer u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .convReq(convReq), .convChan(convChan), .convAck(convAck),
    .convData(convData), .irq(irq)
  );

  int checks = 0, fails = 0;
  logic [14:0] sbQ[$];
  int chanQ[$];
  int expOcc = 0, ackCount = 0, lastGap = -1, lowRun = 0;
  bit sawAck = 0;
  logic [11:0] sampleCtr = 12'h100;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // converter model and scoreboard driver
  initial begin : conv_model
    int lat;
    lat = 0;
    forever begin
      @(negedge clk);
      if (convAck) begin convAck = 1'b0; sawAck = 1; lowRun = 0; end
      if (sawAck) begin
        if (!convReq) lowRun++;
        else begin lastGap = lowRun; sawAck = 0; end
      end
      if (convReq) begin
        if (lat == LAT) begin
          int c;
          lat = 0;
          c = (chanQ.size() > 0) ? chanQ.pop_front() : -1;
          check(c >= 0 && convChan == 3'(c), "R3/R4 slot channel", convChan, c);
          convAck  = 1'b1;
          convData = sampleCtr;
          if (expOcc < 32) begin
            sbQ.push_back({3'(c), sampleCtr});
            expOcc++;
          end
          ackCount++;
          sampleCtr++;
        end else lat++;
      end else lat = 0;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(2'd0, s);
      if (s[30:28] == 3'b000) break;
    end
  endtask

  task automatic drainOne(input string tag);
    logic [31:0] v;
    logic [14:0] e;
    rd(2'd3, v);
    e = (sbQ.size() > 0) ? sbQ.pop_front() : 15'h7fff;
    expOcc--;
    check(v == {17'b0, e}, tag, v, e);
  endtask

  initial begin : watchdog
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] s;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, s); check(s == 32'h0400_0000, "R1 status after reset", s, 32'h0400_0000);
    rd(2'd1, s); check(s == 0, "R1 list after reset", s, 0);
    check(!convReq && !irq, "R1 outputs idle", {convReq, irq}, 0);

    // single-shot three slots: 5,2,7 ; gap 4 cycles
    chanQ = '{5, 2, 7};
    wr(2'd1, 32'h0200_01D5);
    wr(2'd2, 32'h0000_0003);
    wr(2'd0, 32'h0000_0005);
    rd(2'd0, s);
    check(s[28] == 1'b1, "R2 busy after start", s[28], 1);
    check(convReq && convChan == 3'd5, "R2 first request slot0", {convReq, convChan}, 4'hD);
    waitIdle();
    check(lastGap == 4, "R7 gap sel0 cnt3", lastGap, 4);
    rd(2'd0, s);
    check(s[25:21] == 5'd3 && !s[26] && !s[27], "R6 count after run", s[27:21], 3);
    check(s[30:28] == 3'b000, "R3 single-shot goes idle", s[30:28], 0);
    repeat (3) drainOne("R5 drain three");
    rd(2'd3, s); check(s == 0, "R10 empty read value", s, 0);
    rd(2'd0, s); check(s[25:21] == 0 && s[26], "R10 count unchanged", s[26:21], 6'h20);

    // two slots 6,1 ; gap (1+1)*4 = 8
    chanQ = '{6, 1};
    wr(2'd1, 32'h0100_000E);
    wr(2'd2, 32'h0000_0101);
    wr(2'd0, 32'h0000_0005);
    waitIdle();
    check(lastGap == 8, "R7 gap sel1 cnt1", lastGap, 8);
    rd(2'd0, s); check(s[25:21] == 5'd2, "R3 two results", s[25:21], 2);
    repeat (2) drainOne("R5 drain two");

    // continuous 3,4 with busy restart and stop; irq thr 4
    for (int i = 0; i < 40; i++) chanQ.push_back((i % 2 == 0) ? 3 : 4);
    wr(2'd2, 32'h0000_0000);
    wr(2'd1, 32'h0100_0023);
    ackCount = 0;
    wr(2'd0, 32'h0000_004F);
    for (int i = 0; i < 2000; i++) begin
      rd(2'd0, s);
      if (s[25:21] >= 5'd5) break;
    end
    wr(2'd0, 32'h0000_004F);          // start while busy: ignored (R9)
    repeat (4) @(negedge clk);
    wr(2'd0, 32'h0000_404B);          // stop (R8)
    waitIdle();
    rd(2'd0, s);
    check(int'(s[25:21]) == ackCount, "R8 last result stored at idle", s[25:21], ackCount);
    check(ackCount >= 7, "R4 continuous wrapped", ackCount, 7);
    begin
      bit sawReq;
      sawReq = 0;
      repeat (20) begin @(negedge clk); if (convReq) sawReq = 1; end
      check(!sawReq, "R8 no request after stop", sawReq, 0);
    end
    chanQ.delete();
    while (expOcc > 4) drainOne("R9 order kept");
    #1 check(irq == 1'b1, "R12 irq at threshold", irq, 1);
    drainOne("R5 drain");
    #1 check(irq == 1'b0, "R12 irq below threshold", irq, 0);
    while (expOcc > 0) drainOne("R5 drain rest");

    // overflow: single slot ch1 continuous
    for (int i = 0; i < 120; i++) chanQ.push_back(1);
    wr(2'd1, 32'h0000_0001);
    wr(2'd0, 32'h0000_0007);
    for (int i = 0; i < 2000; i++) begin
      rd(2'd0, s);
      if (s[27]) break;
    end
    repeat (40) @(negedge clk);
    wr(2'd0, 32'h0000_4003);
    waitIdle();
    chanQ.delete();
    rd(2'd0, s);
    check(s[27] && s[25:21] == 0, "R11 full held at 32", s[27:21], 7'h40);
    check(ackCount > 32, "R11 extra results arrived", ackCount, 33);
    repeat (32) drainOne("R11 oldest kept");
    rd(2'd0, s); check(s[26], "R6 empty after drain", s[26], 1);

    // start without enable
    wr(2'd0, 32'h0000_0004);
    rd(2'd0, s);
    check(s[30:28] == 0 && !convReq, "R9 start without enable", {s[30:28], convReq}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule